// File: doc/BRIEF.md
# ADC conversion sequencer

This block is the digital control side of an eight-input, 12-bit successive-approximation converter. Software writes one 8-bit control byte through a single-cycle write strobe. That byte picks the input, the span and the polarity, the conversion clock source, how acquisition is timed, and whether the converter should power down. The write itself starts the work. The block runs an acquisition phase, latches the chosen input, and then resolves the result one bit per step, most significant bit first. A not-ready flag stays high for the whole sequence. The finished code is placed in a result register that can be read at any time, including while the block is powered down.

The analog front end is not modelled. Each input instead provides a signed sample word, in units of 10 V / 4096. The block scales and clamps that word to the selected span. It produces straight binary for the unipolar spans and two's complement for the bipolar spans. Standby and full power-down are entered only when a conversion finishes. After full power-down, the next start waits for a parameterised warm-up time.

Top module: `adc_conv_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `result` is 0, `pwr_state` is 0 (active) and the conversion clock is internal.
- R2: In internal-clock mode, a control write with bit 5 = 0 sets `busy` on its own clock edge. Six acquisition edges and then twelve approximation edges follow, so `result` updates and `busy` falls on the 18th edge after the write edge.
- R3: Bits 4 (span) and 3 (polarity) format the sample `v`, whose least significant bit is 10 V/4096. For 0–5 V the result is 2v clamped to 0..4095. For 0–10 V it is v clamped to 0..4095. For ±5 V it is v clamped to −2048..2047, in two's complement. For ±10 V it is floor(v/2) clamped to −2048..2047.
- R4: Bits 2..0 of the control byte select which of the eight sample inputs is converted.
- R5: Bits 7..6 = 00 select the external conversion clock. In that mode, acquisition and approximation steps advance only on edges where `ext_tick` is 1. Bits 7..6 = 01 select the internal clock, which advances on every edge.
- R6: With bit 5 = 1, acquisition is held open until the next write. A following write with bit 7 = 0 and bit 5 = 0 latches the sample at its own edge, using its own byte's input and span. Twelve approximation edges follow.
- R7: A write with bit 7 = 0 while `busy` is high aborts the sequence and starts a fresh acquisition with the new byte. `result` keeps its old value until the new sequence completes.
- R8: A write with bit 7 = 1 chooses standby (bit 6 = 0) or full power-down (bit 6 = 1). While busy, it does not abort: the running conversion finishes, and then `pwr_state` becomes 1 (standby) or 2 (full). When idle, it starts a conversion with its byte and enters that state on completion.
- R9: A write while powered down returns `pwr_state` to 0 on its edge. From standby, acquisition starts at once. From full power-down, it starts only after WAKE_CYC further edges.
- R10: `result` changes only on the edge where a conversion completes, and it holds its value while powered down.
- R11: A bit-7 = 0 write on the completing edge aborts that conversion. A bit-7 = 1 write on the completing edge sets the power state that is entered on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control write strobe, one cycle per byte |
| wr_data | input | 8 | Control byte |
| ext_tick | input | 1 | External conversion clock enable |
| samples | input | 8*VIN_W | Signed sample words, input 0 in the low bits |
| busy | output | 1 | Not-ready flag |
| result | output | 12 | Last completed conversion code |
| pwr_state | output | 2 | 0 active, 1 standby, 2 full power-down |

## Verification
Two events can fall on the same clock edge: a conversion completing and a new control write arriving. The bench provokes this by issuing the write exactly seventeen negative edges after a start, so that it lands on the 18th edge. It does this once with a normal byte, which must win and suppress the result update. It does it once with a power-down byte, whose state must apply on that same edge. A behavioural model built on remaining-cycle counts judges every edge of these runs, as it does every other edge, using `busy`, `result` and `pwr_state`.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and constants of the conversion sequencer.
// Assumes the control byte layout is fixed: power bits on top, channel bits at the bottom.
package adc_seq_pkg;

    localparam int CHAN_W = 3;
    localparam int NCH    = 1 << CHAN_W;

    // Control byte, most significant field first
    typedef struct packed {
        logic              pd_hi;    // 1: power-down request
        logic              pd_lo;    // clock select / full-vs-standby
        logic              acq_ext;  // 1: acquisition held open until next write
        logic              span;     // 1: wide span
        logic              bipol;    // 1: bipolar, two's complement
        logic [CHAN_W-1:0] chan;
    } ctl_byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE,
        PH_ACQ,
        PH_HOLD,
        PH_CONV
    } phase_t;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_STBY = 2'd1,
        PWR_FULL = 2'd2
    } pwr_t;

endpackage

// File: rtl/adc_code_fmt.sv
// Module: adc_code_fmt
// Scales a signed sample (LSB = 10 V / 2^RES_W) to the selected span and clamps it.
// Unipolar output is straight binary; bipolar output is two's complement.
// Assumes VIN_W + 2 bits hold twice the largest sample.
module adc_code_fmt #(
    parameter int VIN_W = 14,
    parameter int RES_W = 12
) (
    input  logic [VIN_W-1:0] vin,
    input  logic             span,
    input  logic             bipol,
    output logic [RES_W-1:0] code
);
    localparam int WW = VIN_W + 2;
    localparam logic signed [WW-1:0] U_MAX = WW'((2 ** RES_W) - 1);
    localparam logic signed [WW-1:0] B_MAX = WW'((2 ** (RES_W - 1)) - 1);
    localparam logic signed [WW-1:0] B_MIN = WW'(-(2 ** (RES_W - 1)));

    logic signed [WW-1:0] ext_v;
    logic signed [WW-1:0] scaled;
    logic signed [WW-1:0] lo_lim;
    logic signed [WW-1:0] hi_lim;
    logic signed [WW-1:0] clamped;

    // Purpose: sign-extend, scale by span, then clamp to the code range.
    always_comb begin
        ext_v = {{2{vin[VIN_W-1]}}, vin};
        case ({bipol, span})
            2'b00:   scaled = ext_v <<< 1;
            2'b01:   scaled = ext_v;
            2'b10:   scaled = ext_v;
            default: scaled = ext_v >>> 1;
        endcase
        lo_lim = bipol ? B_MIN : '0;
        hi_lim = bipol ? B_MAX : U_MAX;
        if (scaled < lo_lim)
            clamped = lo_lim;
        else if (scaled > hi_lim)
            clamped = hi_lim;
        else
            clamped = scaled;
        code = clamped[RES_W-1:0];
    end

endmodule

// File: rtl/adc_sar_core.sv
// Module: adc_sar_core
// Bitwise successive approximation against a latched unsigned target, MSB first.
// A load clears the estimate; each step resolves one bit; last is high on the final step.
module adc_sar_core #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [RES_W-1:0] target,
    output logic [RES_W-1:0] acc_nxt,
    output logic             last
);
    localparam int IW = $clog2(RES_W);

    logic [IW-1:0]    idx;
    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] tgt;
    logic [RES_W-1:0] trial;

    // Purpose: try the current bit and keep it if the trial does not overshoot.
    always_comb begin
        trial   = acc | (RES_W'(1) << idx);
        acc_nxt = (trial <= tgt) ? trial : acc;
        last    = (idx == '0);
    end

    // Purpose: hold the estimate, the bit index and the latched target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
            tgt <= '0;
        end else if (load) begin
            acc <= '0;
            idx <= IW'(RES_W - 1);
            tgt <= target;
        end else if (step) begin
            acc <= acc_nxt;
            idx <= idx - 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl
// Phase sequencer: wake-up, acquisition (timed or held), approximation, power state.
// A normal write restarts the cycle. A power-down write while busy only records the
// request, and the request is applied on the completing edge.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ACQ_CYC  = 6,
    parameter int WAKE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              ext_tick,
    input  logic              sar_last,
    output logic              sar_load,
    output logic              sar_step,
    output logic              conv_done,
    output logic [CHAN_W-1:0] sel_chan,
    output logic              sel_span,
    output logic              sel_bipol,
    output logic              cfg_bipol,
    output logic              busy,
    output logic [1:0]        pwr_state
);
    localparam int MAXC = (ACQ_CYC > WAKE_CYC) ? ACQ_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    ctl_byte_t         wb;
    phase_t            phase;
    pwr_t              pwr, pend, pend_eff, wr_mode;
    logic [CW-1:0]     cnt;
    logic [CHAN_W-1:0] cfg_chan;
    logic              cfg_span, cfg_acq, ext_clk;
    logic              pd_busy_wr, normal_wr, tick, hold_go, acq_end;

    assign wb = ctl_byte_t'(wr_data);

    // Purpose: classify the write and derive this edge's step enables.
    always_comb begin
        busy       = (phase != PH_IDLE);
        pd_busy_wr = wr_en && wb.pd_hi && busy;
        normal_wr  = wr_en && !pd_busy_wr;
        tick       = !ext_clk || ext_tick;
        wr_mode    = wb.pd_lo ? PWR_FULL : PWR_STBY;
        hold_go    = normal_wr && (phase == PH_HOLD) && !wb.acq_ext;
        acq_end    = !normal_wr && (phase == PH_ACQ) && tick && (cnt == CW'(ACQ_CYC - 1));
        sar_load   = hold_go || acq_end;
        sar_step   = !normal_wr && (phase == PH_CONV) && tick;
        conv_done  = sar_step && sar_last;
        pend_eff   = pd_busy_wr ? wr_mode : pend;
        sel_chan   = hold_go ? wb.chan  : cfg_chan;
        sel_span   = hold_go ? wb.span  : cfg_span;
        sel_bipol  = hold_go ? wb.bipol : cfg_bipol;
        pwr_state  = pwr;
    end

    // Purpose: phase sequencing, configuration latching and power-state tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            pwr       <= PWR_ON;
            pend      <= PWR_ON;
            ext_clk   <= 1'b0;
            cfg_chan  <= '0;
            cfg_span  <= 1'b0;
            cfg_bipol <= 1'b0;
            cfg_acq   <= 1'b0;
        end else if (normal_wr) begin
            cfg_chan  <= wb.chan;
            cfg_span  <= wb.span;
            cfg_bipol <= wb.bipol;
            cfg_acq   <= wb.acq_ext;
            if (!wb.pd_hi)
                ext_clk <= !wb.pd_lo;
            pend <= wb.pd_hi ? wr_mode : PWR_ON;
            pwr  <= PWR_ON;
            if (hold_go) begin
                phase <= PH_CONV;
            end else if (phase == PH_WAKE) begin
                phase <= PH_WAKE;
            end else if (phase == PH_IDLE && pwr == PWR_FULL) begin
                phase <= PH_WAKE;
                cnt   <= '0;
            end else begin
                phase <= wb.acq_ext ? PH_HOLD : PH_ACQ;
                cnt   <= '0;
            end
        end else begin
            if (pd_busy_wr)
                pend <= wr_mode;
            case (phase)
                PH_WAKE: begin
                    if (cnt == CW'(WAKE_CYC - 1)) begin
                        phase <= cfg_acq ? PH_HOLD : PH_ACQ;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ACQ: begin
                    if (acq_end) begin
                        phase <= PH_CONV;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (conv_done) begin
                        phase <= PH_IDLE;
                        pwr   <= pend_eff;
                        pend  <= PWR_ON;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Module: adc_conv_seq (top)
// Control byte in, sequenced approximation, formatted result out.
// Samples arrive as a flat bus of signed words, input 0 in the low bits.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int VIN_W    = 14,
    parameter int RES_W    = 12,
    parameter int ACQ_CYC  = 6,
    parameter int WAKE_CYC = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic                 ext_tick,
    input  logic [NCH*VIN_W-1:0] samples,
    output logic                 busy,
    output logic [RES_W-1:0]     result,
    output logic [1:0]           pwr_state
);
    localparam logic [RES_W-1:0] MSB_M = RES_W'(1) << (RES_W - 1);

    logic [VIN_W-1:0]  vin_arr [NCH];
    logic [CHAN_W-1:0] sel_chan;
    logic              sel_span, sel_bipol, cfg_bipol;
    logic              sar_load, sar_step, sar_last, conv_done;
    logic [RES_W-1:0]  fmt_code, sar_target, acc_nxt;

    // Purpose: split the flat sample bus into one word per input.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_unpack
        assign vin_arr[ch] = samples[ch*VIN_W +: VIN_W];
    end

    adc_seq_ctrl #(
        .ACQ_CYC  (ACQ_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ext_tick  (ext_tick),
        .sar_last  (sar_last),
        .sar_load  (sar_load),
        .sar_step  (sar_step),
        .conv_done (conv_done),
        .sel_chan  (sel_chan),
        .sel_span  (sel_span),
        .sel_bipol (sel_bipol),
        .cfg_bipol (cfg_bipol),
        .busy      (busy),
        .pwr_state (pwr_state)
    );

    adc_code_fmt #(
        .VIN_W (VIN_W),
        .RES_W (RES_W)
    ) u_fmt (
        .vin   (vin_arr[sel_chan]),
        .span  (sel_span),
        .bipol (sel_bipol),
        .code  (fmt_code)
    );

    // Purpose: map two's complement onto an offset scale so the approximation compares unsigned.
    assign sar_target = sel_bipol ? (fmt_code ^ MSB_M) : fmt_code;

    adc_sar_core #(
        .RES_W (RES_W)
    ) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sar_load),
        .step    (sar_step),
        .target  (sar_target),
        .acc_nxt (acc_nxt),
        .last    (sar_last)
    );

    // Purpose: update the readable result only when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (conv_done)
            result <= cfg_bipol ? (acc_nxt ^ MSB_M) : acc_nxt;
    end

endmodule

// File: rtl/adc_conv_seq_chk.sv
// Module: adc_conv_seq_chk
// Port-level temporal checks on the sequencer, attached by bind below.
module adc_conv_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             busy,
    input logic [RES_W-1:0] result,
    input logic [1:0]       pwr_state
);
    // R1: first cycle out of reset is idle, cleared and active
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && result == '0 && pwr_state == 2'd0));

    // R2: the not-ready flag only rises because of a write
    assert_busy_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R10: result moves only on a completing edge
    assert_result_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));

    // R8: a powered-down block is never busy
    assert_pd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0) |-> !busy);

    // R8: power-down is entered only as a conversion ends
    assert_pd_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'd0 && pwr_state != 2'd0) |-> $fell(busy));

    // R9: power-down is left only through a write
    assert_pd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) != 2'd0 && pwr_state == 2'd0) |-> $past(wr_en));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .result    (result),
    .pwr_state (pwr_state)
);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural model built on remaining-cycle counts, compared with the design every clock.
module sim_adc_conv_seq;
    localparam int VIN_W = 14;
    localparam int WAKE  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic ext_tick = 1'b0;
    logic [8*VIN_W-1:0] samples;
    logic busy;
    logic [11:0] result;
    logic [1:0] pwr_state;

    int smp [8];
    int n_cmp = 0, n_bad = 0, cyc = 0, tick_cnt = 0;
    bit chk_on = 0, finished = 0;
    string cur_req = "R1";

    // model state
    int ph, rem, m_chan, m_span, m_bip, m_acq, m_ext, m_pend, m_pwr, m_res, m_code;
    bit m_busy;

    always #4 clk = ~clk;

    adc_conv_seq #(.VIN_W(VIN_W), .WAKE_CYC(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ext_tick(ext_tick), .samples(samples), .busy(busy),
        .result(result), .pwr_state(pwr_state)
    );

    always_comb
        for (int i = 0; i < 8; i++) samples[i*VIN_W +: VIN_W] = VIN_W'(smp[i]);

    function automatic int fmt(int v, int span, int bip);
        int x, lo, hi;
        if (bip == 0) begin x = (span != 0) ? v : 2 * v; lo = 0; hi = 4095; end
        else begin x = (span != 0) ? ((v < 0) ? -((1 - v) / 2) : v / 2) : v; lo = -2048; hi = 2047; end
        if (x < lo) x = lo;
        if (x > hi) x = hi;
        return x & 12'hFFF;
    endfunction

    task automatic advance(bit tk);
        case (ph)
            1: begin rem--; if (rem == 0) begin ph = (m_acq != 0) ? 3 : 2; rem = 6; end end
            2: if (tk) begin
                   rem--;
                   if (rem == 0) begin m_code = fmt(smp[m_chan], m_span, m_bip); ph = 4; rem = 12; end
               end
            4: if (tk) begin
                   rem--;
                   if (rem == 0) begin m_res = m_code; ph = 0; m_pwr = m_pend; m_pend = 0; end
               end
            default: ;
        endcase
    endtask

    // Reference model, evaluated on each rising edge with the inputs as driven
    always @(posedge clk) begin
        bit tk;
        logic [7:0] b;
        if (!rst_n) begin
            ph = 0; rem = 0; m_chan = 0; m_span = 0; m_bip = 0; m_acq = 0;
            m_ext = 0; m_pend = 0; m_pwr = 0; m_res = 0; m_code = 0;
        end else begin
            tk = (m_ext == 0) || ext_tick;
            b = wr_data;
            if (wr_en && b[7] && ph != 0) begin
                m_pend = b[6] ? 2 : 1;
                advance(tk);
            end else if (wr_en) begin
                m_chan = b[2:0]; m_span = b[4]; m_bip = b[3]; m_acq = b[5];
                if (!b[7]) m_ext = (b[6] == 1'b0) ? 1 : 0;
                m_pend = b[7] ? (b[6] ? 2 : 1) : 0;
                if (ph == 3 && !b[5]) begin
                    m_code = fmt(smp[m_chan], m_span, m_bip); ph = 4; rem = 12;
                end else if (ph == 1) begin
                end else if (ph == 0 && m_pwr == 2) begin
                    ph = 1; rem = WAKE;
                end else begin
                    ph = b[5] ? 3 : 2; rem = 6;
                end
                m_pwr = 0;
            end else begin
                advance(tk);
            end
        end
        m_busy = (ph != 0);
    end

    // Compare on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            n_cmp++;
            if (busy !== m_busy || result !== m_res[11:0] || pwr_state !== m_pwr[1:0]) begin
                n_bad++;
                $display("FAIL %s busy/result/pwr: actual %0b/%03h/%0d expected %0b/%03h/%0d",
                         cur_req, busy, result, pwr_state, m_busy, m_res[11:0], m_pwr);
            end
        end
    end

    // External conversion clock pattern: one tick in three
    always @(negedge clk) begin
        tick_cnt++;
        ext_tick <= (tick_cnt % 3 == 0);
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] b);
        wr_data = b;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        smp[0] = 1000; smp[1] = -300; smp[2] = 3000; smp[3] = -5000;
        smp[4] = 8191; smp[5] = 0;    smp[6] = 2047; smp[7] = -1;
        repeat (3) @(negedge clk);
        chk_on = 1;                     // R1: reset values compared here
        idle(2);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wr(8'h40); idle(22);
        wr(8'h41); idle(22);

        cur_req = "R3";
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) begin
                int ch;
                ch = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 4 : 7;
                wr(8'h40 | 8'((c & 1) << 4) | 8'((c >> 1) << 3) | 8'(ch));
                idle(20);
            end

        cur_req = "R4";
        for (int ch = 0; ch < 8; ch++) begin
            wr(8'h48 | 8'(ch)); idle(20);
        end

        cur_req = "R5";
        wr(8'h01); idle(60);
        wr(8'h1B); idle(60);
        wr(8'h06); idle(10); wr(8'h07); idle(60);

        cur_req = "R6";
        wr(8'h61); idle(10); wr(8'h52); idle(20);
        wr(8'h63); idle(4); wr(8'h7C); idle(7); wr(8'h4C); idle(20);

        cur_req = "R7";
        wr(8'h41); idle(9); wr(8'h43); idle(25);
        wr(8'h44); idle(2); wr(8'h46); idle(25);

        cur_req = "R8";
        wr(8'h44); idle(5); wr(8'h80); idle(25);
        cur_req = "R9";
        wr(8'h45); idle(25);
        cur_req = "R8";
        wr(8'hC6); idle(25);
        cur_req = "R10";
        idle(15);
        cur_req = "R9";
        wr(8'h47); idle(45);
        wr(8'hC2); idle(25);
        wr(8'h61); idle(30); wr(8'h40); idle(20);

        cur_req = "R11";
        wr(8'h40); idle(17); wr(8'h42); idle(25);
        wr(8'h41); idle(17); wr(8'h80); idle(6);
        wr(8'h43); idle(17); wr(8'hC0); idle(6);
        cur_req = "R10";
        idle(10);
        wr(8'h40); idle(45);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule